// File: doc/BRIEF.md
# Windowed Pixel Array Readout Sequencer

This block produces the frame and row timing that reads a rectangular region of interest out of a pixel array. It runs frames back to back from the release of reset. Each frame opens with a frame overhead interval. The selected lines follow one after another, and each line is a row overhead interval followed by column readout. Columns are read in kernels of 24 pixels, and each kernel takes two clock cycles. For every cycle of column readout the block gives the row address and the kernel address. It pulses a strobe once per kernel.

The window comes in on plain configuration inputs. These give the x start and width in pixels, the y start and height in lines, the two overhead lengths in clock cycles, and a subsampling enable. In subsampling mode the row address advances by two lines instead of one. The block samples these inputs in the first cycle of a frame and holds them for the whole frame, so the inputs may change at any time. When each frame ends, the block reports how many cycles that frame took.

Top module: `roi_readout_seq`

## Requirements
- R1: A frame begins with a frame overhead interval of `cfg_fot_len` cycles, with a length of 0 taken as 1. During this interval `frame_valid`, `line_valid` and `kernel_strobe` are all 0.
- R2: Each line is a row overhead interval of `cfg_rot_len` cycles (0 taken as 1), with `frame_valid`=1 and `line_valid`=0. It is followed by 2×K cycles with `line_valid`=1, where K is the number of kernels per line.
- R3: Within a line, kernel k (counting from 0) takes two cycles. `kernel_strobe` is 1 on the first of these cycles only. During both cycles `kernel_addr` = floor(`cfg_x_start`/24) + k, taken modulo 2^KW.
- R4: K = ceil(`cfg_x_width`/24), so a width that is not a multiple of 24 is rounded up to the next whole kernel. A width of 0 gives K = 1.
- R5: Line i (counting from 0) has `row_addr` = `cfg_y_start` + i×step, taken modulo 2^Y_W. The step is 1 when `cfg_subsample`=0 and 2 when it is 1. The number of lines L is `cfg_y_height` in normal mode and ceil(`cfg_y_height`/2) in subsampling mode. A height of 0 gives L = 1.
- R6: The block samples all configuration inputs only in the first cycle of a frame. A change to them at any other time does not affect the frame in progress.
- R7: `frame_valid` is 1 from the first cycle after the frame overhead through the last cycle of the last kernel of the last line. The next frame's overhead begins in the following cycle.
- R8: `frame_period` changes at the end of each frame to that frame's length, F + L×(R + 2×K) cycles, where F and R are the overhead lengths after the substitution of 0 by 1. It holds this value until the next frame ends.
- R9: During and right after reset, `frame_valid`, `line_valid` and `kernel_strobe` are 0 and `frame_period` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock, one cycle per timeslot |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_x_start | input | X_W | Window x start in pixels |
| cfg_x_width | input | X_W | Window width in pixels |
| cfg_y_start | input | Y_W | Window first line |
| cfg_y_height | input | Y_W | Window height in lines |
| cfg_fot_len | input | O_W | Frame overhead length in cycles |
| cfg_rot_len | input | O_W | Row overhead length in cycles |
| cfg_subsample | input | 1 | 1 selects a row step of two lines |
| frame_valid | output | 1 | Frame readout in progress, after the frame overhead |
| line_valid | output | 1 | Kernel readout in progress |
| kernel_strobe | output | 1 | First timeslot of each kernel |
| row_addr | output | Y_W | Row being read |
| kernel_addr | output | KW | Kernel (column group) being read |
| frame_period | output | PER_W | Length in cycles of the last completed frame |

## Verification
A group of directed frames covers the edge cases. These are overhead lengths of zero, a width of exactly one kernel next to a width one pixel over, a width of zero, a height of zero, odd heights in subsampling mode, and an x start that is not a multiple of 24. Each of these separates a correct rounding or clamp from an off-by-one. Random frames follow, with random window and overhead values. In every cycle that is not the first cycle of a frame, the bench drives fresh random values on the configuration inputs. Any leak of those values into the running frame then shows up as a wrong address or a wrong phase length. In every cycle the bench compares each output against a model indexed by the cycle's position within the frame, so timing slips of a single cycle are caught as well as wrong values.

// File: rtl/roi_seq_pkg.sv
// Shared constants, phase type and width helper for the ROI readout sequencer.
// Assumes: columns are grouped into fixed kernels of KERNEL_PIX pixels.
package roi_seq_pkg;

    localparam int KERNEL_PIX        = 24;
    localparam int SLOTS_PER_KERNEL  = 2;

    typedef enum logic [1:0] {
        PH_FOT  = 2'd0,
        PH_ROT  = 2'd1,
        PH_READ = 2'd2
    } seq_phase_e;

    // Bits needed to hold any kernel index reachable from an x_w-bit pixel value.
    function automatic int kern_addr_bits(input int x_w);
        return $clog2((((1 << x_w) + KERNEL_PIX - 1) / KERNEL_PIX) + 1);
    endfunction

endpackage

// File: rtl/roi_cfg_latch.sv
// Derives the per-frame readout settings from the raw configuration inputs
// and holds them in shadow registers loaded at frame start.
// Assumes: 'load' is high only in the first cycle of a frame. In that cycle
// the live derived values are passed through so the frame uses them at once.
module roi_cfg_latch
    import roi_seq_pkg::*;
#(
    parameter int X_W = 11,
    parameter int Y_W = 11,
    parameter int O_W = 10,
    parameter int KW  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [X_W-1:0] x_start,
    input  logic [X_W-1:0] x_width,
    input  logic [Y_W-1:0] y_start,
    input  logic [Y_W-1:0] y_height,
    input  logic [O_W-1:0] fot_len,
    input  logic [O_W-1:0] rot_len,
    input  logic           subsample,
    output logic [O_W-1:0] eff_fot,
    output logic [O_W-1:0] eff_rot,
    output logic [KW-1:0]  eff_n_kern,
    output logic [KW-1:0]  eff_k_start,
    output logic [Y_W-1:0] eff_n_lines,
    output logic [Y_W-1:0] eff_y_start,
    output logic           eff_sub
);

    logic [X_W:0]   w_sum;
    logic [X_W:0]   k_raw;
    logic [X_W-1:0] ks_raw;
    logic [Y_W:0]   h_half;

    logic [O_W-1:0] d_fot, d_rot, q_fot, q_rot;
    logic [KW-1:0]  d_nk, d_ks, q_nk, q_ks;
    logic [Y_W-1:0] d_nl, q_nl, q_ys;
    logic           q_sub;

    // Clamp lengths, round the width up to whole kernels, count the lines.
    always_comb begin
        w_sum  = {1'b0, x_width} + (X_W+1)'(KERNEL_PIX - 1);
        k_raw  = w_sum / (X_W+1)'(KERNEL_PIX);
        ks_raw = x_start / X_W'(KERNEL_PIX);
        h_half = ({1'b0, y_height} + (Y_W+1)'(1)) >> 1;
        d_fot  = (fot_len == '0) ? O_W'(1) : fot_len;
        d_rot  = (rot_len == '0) ? O_W'(1) : rot_len;
        d_nk   = (x_width == '0) ? KW'(1) : KW'(k_raw);
        d_ks   = KW'(ks_raw);
        if (y_height == '0)
            d_nl = Y_W'(1);
        else if (subsample)
            d_nl = Y_W'(h_half);
        else
            d_nl = y_height;
    end

    // Shadow registers, written only at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_fot <= O_W'(1);
            q_rot <= O_W'(1);
            q_nk  <= KW'(1);
            q_ks  <= '0;
            q_nl  <= Y_W'(1);
            q_ys  <= '0;
            q_sub <= 1'b0;
        end else if (load) begin
            q_fot <= d_fot;
            q_rot <= d_rot;
            q_nk  <= d_nk;
            q_ks  <= d_ks;
            q_nl  <= d_nl;
            q_ys  <= y_start;
            q_sub <= subsample;
        end
    end

    // Bypass the shadow in the loading cycle.
    always_comb begin
        eff_fot     = load ? d_fot     : q_fot;
        eff_rot     = load ? d_rot     : q_rot;
        eff_n_kern  = load ? d_nk      : q_nk;
        eff_k_start = load ? d_ks      : q_ks;
        eff_n_lines = load ? d_nl      : q_nl;
        eff_y_start = load ? y_start   : q_ys;
        eff_sub     = load ? subsample : q_sub;
    end

endmodule

// File: rtl/roi_phase_ctrl.sv
// Phase state machine: frame overhead, then per line row overhead and
// two-slot kernel readout, then back to frame overhead.
// Assumes: all lengths and counts presented are at least 1.
module roi_phase_ctrl
    import roi_seq_pkg::*;
#(
    parameter int Y_W = 11,
    parameter int O_W = 10,
    parameter int KW  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [O_W-1:0] fot_len,
    input  logic [O_W-1:0] rot_len,
    input  logic [KW-1:0]  n_kern,
    input  logic [Y_W-1:0] n_lines,
    output seq_phase_e     phase,
    output logic [KW-1:0]  kern_cnt,
    output logic           slot,
    output logic [Y_W-1:0] line_cnt,
    output logic           frame_start,
    output logic           frame_last
);

    logic [O_W-1:0] ovh_cnt;
    logic           last_kern;
    logic           last_line;

    // Decode the end-of-interval conditions.
    always_comb begin
        last_kern   = (kern_cnt == n_kern - KW'(1));
        last_line   = (line_cnt == n_lines - Y_W'(1));
        frame_start = (phase == PH_FOT) && (ovh_cnt == '0);
        frame_last  = (phase == PH_READ) && slot && last_kern && last_line;
    end

    // Advance the phase and its counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_FOT;
            ovh_cnt  <= '0;
            kern_cnt <= '0;
            slot     <= 1'b0;
            line_cnt <= '0;
        end else begin
            case (phase)
                PH_FOT: begin
                    if (ovh_cnt == fot_len - O_W'(1)) begin
                        phase    <= PH_ROT;
                        ovh_cnt  <= '0;
                        line_cnt <= '0;
                    end else begin
                        ovh_cnt <= ovh_cnt + O_W'(1);
                    end
                end
                PH_ROT: begin
                    if (ovh_cnt == rot_len - O_W'(1)) begin
                        phase    <= PH_READ;
                        ovh_cnt  <= '0;
                        kern_cnt <= '0;
                        slot     <= 1'b0;
                    end else begin
                        ovh_cnt <= ovh_cnt + O_W'(1);
                    end
                end
                PH_READ: begin
                    slot <= ~slot;
                    if (slot) begin
                        if (!last_kern) begin
                            kern_cnt <= kern_cnt + KW'(1);
                        end else if (last_line) begin
                            phase   <= PH_FOT;
                            ovh_cnt <= '0;
                        end else begin
                            phase    <= PH_ROT;
                            ovh_cnt  <= '0;
                            line_cnt <= line_cnt + Y_W'(1);
                        end
                    end
                end
                default: begin
                    phase   <= PH_FOT;
                    ovh_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/roi_addr_gen.sv
// Maps the phase state to the readout outputs: valids, strobe, row and
// kernel address. Purely combinational from registered state.
// Assumes: y step is 1 or 2 lines; addresses wrap at their widths.
module roi_addr_gen
    import roi_seq_pkg::*;
#(
    parameter int Y_W = 11,
    parameter int KW  = 7
) (
    input  seq_phase_e     phase,
    input  logic [KW-1:0]  kern_cnt,
    input  logic           slot,
    input  logic [Y_W-1:0] line_cnt,
    input  logic [KW-1:0]  k_start,
    input  logic [Y_W-1:0] y_start,
    input  logic           sub,
    output logic           frame_valid,
    output logic           line_valid,
    output logic           kernel_strobe,
    output logic [Y_W-1:0] row_addr,
    output logic [KW-1:0]  kernel_addr
);

    logic [Y_W-1:0] row_off;

    // Build valids, strobe and addresses.
    always_comb begin
        row_off       = sub ? {line_cnt[Y_W-2:0], 1'b0} : line_cnt;
        frame_valid   = (phase == PH_ROT) || (phase == PH_READ);
        line_valid    = (phase == PH_READ);
        kernel_strobe = (phase == PH_READ) && !slot;
        row_addr      = y_start + row_off;
        kernel_addr   = k_start + kern_cnt;
    end

endmodule

// File: rtl/roi_period_meter.sv
// Counts the cycles of each frame and publishes the total at frame end.
// Assumes: frame_last is high for exactly the final cycle of a frame.
module roi_period_meter #(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_last,
    output logic [PER_W-1:0] frame_period
);

    logic [PER_W-1:0] cyc;

    // Count within the frame; capture the length on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc          <= '0;
            frame_period <= '0;
        end else if (frame_last) begin
            cyc          <= '0;
            frame_period <= cyc + PER_W'(1);
        end else begin
            cyc <= cyc + PER_W'(1);
        end
    end

endmodule

// File: rtl/roi_readout_seq.sv
// Top of the windowed readout sequencer: configuration shadowing, phase
// control, address mapping and frame length measurement.
// Assumes: frames run back to back from reset release.
module roi_readout_seq
    import roi_seq_pkg::*;
#(
    parameter int X_W   = 11,
    parameter int Y_W   = 11,
    parameter int O_W   = 10,
    parameter int PER_W = 24,
    localparam int KW   = kern_addr_bits(X_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [X_W-1:0]   cfg_x_start,
    input  logic [X_W-1:0]   cfg_x_width,
    input  logic [Y_W-1:0]   cfg_y_start,
    input  logic [Y_W-1:0]   cfg_y_height,
    input  logic [O_W-1:0]   cfg_fot_len,
    input  logic [O_W-1:0]   cfg_rot_len,
    input  logic             cfg_subsample,
    output logic             frame_valid,
    output logic             line_valid,
    output logic             kernel_strobe,
    output logic [Y_W-1:0]   row_addr,
    output logic [KW-1:0]    kernel_addr,
    output logic [PER_W-1:0] frame_period
);

    logic [O_W-1:0] eff_fot, eff_rot;
    logic [KW-1:0]  eff_n_kern, eff_k_start, kern_cnt;
    logic [Y_W-1:0] eff_n_lines, eff_y_start, line_cnt;
    logic           eff_sub, slot, frame_start, frame_last;
    seq_phase_e     phase;

    roi_cfg_latch #(.X_W(X_W), .Y_W(Y_W), .O_W(O_W), .KW(KW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (frame_start),
        .x_start     (cfg_x_start),
        .x_width     (cfg_x_width),
        .y_start     (cfg_y_start),
        .y_height    (cfg_y_height),
        .fot_len     (cfg_fot_len),
        .rot_len     (cfg_rot_len),
        .subsample   (cfg_subsample),
        .eff_fot     (eff_fot),
        .eff_rot     (eff_rot),
        .eff_n_kern  (eff_n_kern),
        .eff_k_start (eff_k_start),
        .eff_n_lines (eff_n_lines),
        .eff_y_start (eff_y_start),
        .eff_sub     (eff_sub)
    );

    roi_phase_ctrl #(.Y_W(Y_W), .O_W(O_W), .KW(KW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fot_len     (eff_fot),
        .rot_len     (eff_rot),
        .n_kern      (eff_n_kern),
        .n_lines     (eff_n_lines),
        .phase       (phase),
        .kern_cnt    (kern_cnt),
        .slot        (slot),
        .line_cnt    (line_cnt),
        .frame_start (frame_start),
        .frame_last  (frame_last)
    );

    roi_addr_gen #(.Y_W(Y_W), .KW(KW)) u_addr (
        .phase         (phase),
        .kern_cnt      (kern_cnt),
        .slot          (slot),
        .line_cnt      (line_cnt),
        .k_start       (eff_k_start),
        .y_start       (eff_y_start),
        .sub           (eff_sub),
        .frame_valid   (frame_valid),
        .line_valid    (line_valid),
        .kernel_strobe (kernel_strobe),
        .row_addr      (row_addr),
        .kernel_addr   (kernel_addr)
    );

    roi_period_meter #(.PER_W(PER_W)) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_last   (frame_last),
        .frame_period (frame_period)
    );

endmodule

// File: rtl/roi_readout_seq_chk.sv
// Temporal checks on the sequencer outputs, bound into the top module.
module roi_readout_seq_chk #(
    parameter int Y_W   = 11,
    parameter int KW    = 7,
    parameter int PER_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_valid,
    input logic             line_valid,
    input logic             kernel_strobe,
    input logic [Y_W-1:0]   row_addr,
    input logic [KW-1:0]    kernel_addr,
    input logic [PER_W-1:0] frame_period
);

    AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid); // R2

    AST_STROBE_INSIDE_LV: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_strobe |-> line_valid); // R3

    AST_STROBE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_strobe |=> (line_valid && !kernel_strobe)); // R3

    AST_LINE_OPENS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> kernel_strobe); // R3

    AST_KADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (kernel_strobe && $past(line_valid)) |-> (kernel_addr == KW'($past(kernel_addr) + KW'(1)))); // R3

    AST_ROW_HELD_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid)) |-> $stable(row_addr)); // R5

    AST_FRAME_ENDS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_valid) |-> $past(line_valid)); // R7

    AST_PERIOD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_valid) |-> (frame_period != '0)); // R8

endmodule

bind roi_readout_seq roi_readout_seq_chk #(.Y_W(Y_W), .KW(KW), .PER_W(PER_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid   (frame_valid),
    .line_valid    (line_valid),
    .kernel_strobe (kernel_strobe),
    .row_addr      (row_addr),
    .kernel_addr   (kernel_addr),
    .frame_period  (frame_period)
);

// File: tb/roi_readout_seq_tb_top.sv
// Self-checking bench: directed corner frames then random frames, with the
// configuration scrambled on every cycle except a frame's first.
module roi_readout_seq_tb_top;

    localparam int X_W   = 11;
    localparam int Y_W   = 11;
    localparam int O_W   = 10;
    localparam int PER_W = 24;
    localparam int KW    = roi_seq_pkg::kern_addr_bits(X_W);
    localparam int N_FRAMES = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [X_W-1:0]   cfg_x_start = '0;
    logic [X_W-1:0]   cfg_x_width = '0;
    logic [Y_W-1:0]   cfg_y_start = '0;
    logic [Y_W-1:0]   cfg_y_height = '0;
    logic [O_W-1:0]   cfg_fot_len = '0;
    logic [O_W-1:0]   cfg_rot_len = '0;
    logic             cfg_subsample = 1'b0;
    logic             frame_valid, line_valid, kernel_strobe;
    logic [Y_W-1:0]   row_addr;
    logic [KW-1:0]    kernel_addr;
    logic [PER_W-1:0] frame_period;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state for the current frame.
    int mF, mR, mK, mKs, mL, mYs, mStep, mP;
    int exp_period = 0;

    always #2 clk = ~clk;

    roi_readout_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_x_start   (cfg_x_start),
        .cfg_x_width   (cfg_x_width),
        .cfg_y_start   (cfg_y_start),
        .cfg_y_height  (cfg_y_height),
        .cfg_fot_len   (cfg_fot_len),
        .cfg_rot_len   (cfg_rot_len),
        .cfg_subsample (cfg_subsample),
        .frame_valid   (frame_valid),
        .line_valid    (line_valid),
        .kernel_strobe (kernel_strobe),
        .row_addr      (row_addr),
        .kernel_addr   (kernel_addr),
        .frame_period  (frame_period)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive_cfg(input int f, input int r, input int xs, input int w,
                             input int ys, input int h, input int sub);
        cfg_fot_len   = O_W'(f);
        cfg_rot_len   = O_W'(r);
        cfg_x_start   = X_W'(xs);
        cfg_x_width   = X_W'(w);
        cfg_y_start   = Y_W'(ys);
        cfg_y_height  = Y_W'(h);
        cfg_subsample = sub[0];
    endtask

    task automatic scramble();
        drive_cfg($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 2047),
                  $urandom_range(0, 2047), $urandom_range(0, 2047), $urandom_range(0, 2047),
                  $urandom_range(0, 1));
    endtask

    // Compute the model's frame settings from R1, R2, R4, R5 and R8.
    task automatic latch_model(input int f, input int r, input int xs, input int w,
                               input int ys, input int h, input int sub);
        mF    = (f == 0) ? 1 : f;
        mR    = (r == 0) ? 1 : r;
        mK    = (w == 0) ? 1 : (w + 23) / 24;
        mKs   = xs / 24;
        mL    = (h == 0) ? 1 : (sub != 0 ? (h + 1) / 2 : h);
        mYs   = ys;
        mStep = (sub != 0) ? 2 : 1;
        mP    = mF + mL * (mR + 2 * mK);
    endtask

    // Compare every output with the model at cycle t of the frame.
    task automatic check_cycle(input int t);
        int u, line, w, k;
        bit efv, elv, est;
        efv = (t >= mF);
        elv = 1'b0;
        est = 1'b0;
        k = 0;
        line = 0;
        if (efv) begin
            u    = t - mF;
            line = u / (mR + 2 * mK);
            w    = u % (mR + 2 * mK);
            if (w >= mR) begin
                elv = 1'b1;
                k   = (w - mR) / 2;
                est = ((w - mR) % 2 == 0);
            end
        end
        chk(frame_valid == efv, "R1/R7", "frame_valid", int'(frame_valid), int'(efv));
        chk(line_valid == elv, "R2", "line_valid", int'(line_valid), int'(elv));
        chk(kernel_strobe == est, "R3", "kernel_strobe", int'(kernel_strobe), int'(est));
        if (elv) begin
            chk(int'(kernel_addr) == ((mKs + k) % (1 << KW)), "R3/R4", "kernel_addr",
                int'(kernel_addr), (mKs + k) % (1 << KW));
            chk(int'(row_addr) == ((mYs + line * mStep) % (1 << Y_W)), "R5/R6", "row_addr",
                int'(row_addr), (mYs + line * mStep) % (1 << Y_W));
        end
        chk(int'(frame_period) == exp_period, "R8", "frame_period",
            int'(frame_period), exp_period);
    endtask

    initial begin
        int f, r, xs, w, ys, h, sub;
        scramble();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(!frame_valid && !line_valid && !kernel_strobe, "R9", "valids in reset",
            int'({frame_valid, line_valid, kernel_strobe}), 0);
        chk(frame_period == '0, "R9", "frame_period in reset", int'(frame_period), 0);
        rst_n = 1'b1;
        for (int fr = 0; fr < N_FRAMES; fr++) begin
            if (fr > 0) @(negedge clk);
            // First cycle of the frame: outputs first, then the frame settings.
            case (fr)
                0: begin f = 0;   r = 0; xs = 0;   w = 24; ys = 0;    h = 1; sub = 0; end // R1 R2 zero overheads
                1: begin f = 5;   r = 3; xs = 48;  w = 25; ys = 10;   h = 3; sub = 0; end // R4 round up
                2: begin f = 2;   r = 1; xs = 47;  w = 0;  ys = 100;  h = 5; sub = 1; end // R4 zero width, R5 odd subsample
                3: begin f = 1;   r = 2; xs = 24;  w = 48; ys = 7;    h = 0; sub = 1; end // R5 zero height
                4: begin f = 315; r = 9; xs = 240; w = 72; ys = 2046; h = 4; sub = 0; end // R5 row wrap
                5: begin f = 3;   r = 4; xs = 2040; w = 23; ys = 2045; h = 4; sub = 1; end // R3 R5 top of range
                default: begin
                    f = $urandom_range(0, 40);  r = $urandom_range(0, 12);
                    xs = $urandom_range(0, 2047); w = $urandom_range(0, 200);
                    ys = $urandom_range(0, 2047); h = $urandom_range(0, 12);
                    sub = $urandom_range(0, 1);
                end
            endcase
            chk(!frame_valid && !line_valid, "R7", "frame start idle",
                int'({frame_valid, line_valid}), 0);
            chk(int'(frame_period) == exp_period, "R8", "frame_period at start",
                int'(frame_period), exp_period);
            drive_cfg(f, r, xs, w, ys, h, sub);
            latch_model(f, r, xs, w, ys, h, sub);
            for (int t = 1; t < mP; t++) begin
                @(negedge clk);
                check_cycle(t);
                scramble(); // R6: must not affect this frame
            end
            exp_period = mP;
        end
        @(negedge clk);
        chk(int'(frame_period) == exp_period, "R8", "final frame_period",
            int'(frame_period), exp_period);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd20240611);
    end

endmodule